// File: doc/BRIEF.md
# Core Reset Delay and Watchdog Controller

This block produces the reset that holds a small microcontroller core. A reset-hold delay timer keeps the core reset asserted for a fixed number of slow-clock cycles after any of three events: a power-on reset pulse, the end of an external active-low master-clear, or a watchdog expiry. A watchdog counter runs next to it. The core must clear the watchdog periodically, and if it fails to, the watchdog forces a full reset hold. All state is clocked by a dedicated free-running slow clock, so both timers keep running while the main processor clock is stopped in sleep.

A timeout status flag records why the core last came out of reset. A watchdog expiry drives the flag low. Power-on reset or a clear-watchdog request drives it high. When a watchdog expiry happens in sleep, the block also emits a one-cycle wake-up pulse. Two configuration bits shape the behaviour. One turns the watchdog off permanently. The other turns the master-clear pin into a plain input, whose synchronized level is then presented on a general-purpose output.

Top module: `rdw_core_reset`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1. After `por_i` falls, `core_rst_o` stays 1 for exactly `DRT_CYCLES` rising edges of `clk_lf_i` and is 0 after the `DRT_CYCLES`-th edge.
- R2: While `por_i` is high, `to_flag_o` is 1 and `wake_o` is 0.
- R3: With `cfg_mclr_en_i`=1, a low level on `mclr_n_i` asserts `core_rst_o` on the third rising edge after the pin falls, and keeps it asserted while the pin stays low. After the pin returns high, `core_rst_o` falls on edge `DRT_CYCLES`+2.
- R4: With `cfg_wdt_en_i`=1, the watchdog counts slow-clock edges from the edge on which `core_rst_o` falls. It counts in sleep and out of sleep. If it is not cleared, `core_rst_o` rises again on edge `WDT_CYCLES` after the release and is then held for `DRT_CYCLES` edges, as in R1.
- R5: If `sleep_i` has been high for at least two edges when a watchdog expiry occurs, `wake_o` is 1 for exactly the one cycle following the expiry edge. An expiry outside sleep leaves `wake_o` at 0.
- R6: A watchdog expiry drives `to_flag_o` to 0 on the expiry edge.
- R7: With `cfg_wdt_en_i`=0, the watchdog never expires, and `core_rst_o` and `to_flag_o` keep their values for any length of time.
- R8: A rising level on `wdt_clr_i` restarts the watchdog count from zero on the third edge after the rise. The next expiry then comes `WDT_CYCLES` edges after that edge.
- R9: A rising level on `wdt_clr_i` drives `to_flag_o` to 1 on the third edge after the rise.
- R10: With `cfg_mclr_en_i`=0, `mclr_n_i` has no effect on `core_rst_o`, and `gpin_o` follows the pin level two edges late. With `cfg_mclr_en_i`=1, `gpin_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf_i | input | 1 | Free-running slow clock for all state |
| por_i | input | 1 | Power-on reset pulse, active high, asynchronous |
| mclr_n_i | input | 1 | External master-clear pin, active low |
| sleep_i | input | 1 | Core is in sleep (main clock stopped) |
| wdt_clr_i | input | 1 | Clear-watchdog request, acts on its rising level |
| cfg_wdt_en_i | input | 1 | Configuration: 1 enables the watchdog |
| cfg_mclr_en_i | input | 1 | Configuration: 1 makes the pin a reset source |
| core_rst_o | output | 1 | Core reset, active high, registered |
| wake_o | output | 1 | One-cycle pulse on a watchdog expiry during sleep |
| to_flag_o | output | 1 | Timeout status: 0 after a watchdog expiry |
| gpin_o | output | 1 | Synchronized pin level when the pin is not a reset source |

## Verification
A reset-hold counter that starts from a wrong value shows up as a `core_rst_o` release that is early or late. The bench pins down the exact release edge after every restart cause. A watchdog count that is not held during reset, or not restarted by a clear, moves the next expiry by whole cycles. That error shows on `core_rst_o` one period later, so the checks sample the edge just before and the edge of each expected expiry. A wrong flag or wake update is visible on `to_flag_o` or `wake_o` in the cycle right after the causing edge.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

    // Bit positions inside the synchronizer bus
    localparam int SYN_W     = 3;
    localparam int SYN_PIN   = 0;
    localparam int SYN_CLR   = 1;
    localparam int SYN_SLEEP = 2;

    // Reset value of the synchronizer bus: pin idles high, others low
    localparam logic [SYN_W-1:0] SYN_IDLE = 3'b001;

    typedef struct packed {
        logic clr_prev;
        logic to_flag;
        logic wake;
    } top_state_t;

endpackage

// File: rtl/rdw_sync.sv
module rdw_sync #(
    parameter int            WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/rdw_drt.sv
module rdw_drt #(
    parameter int CYCLES = 576
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic busy_o,
    output logic hold_o
);

    localparam int        CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } drt_t;

    drt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.hold = (st_d.cnt != '0);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '{cnt: LOAD, hold: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.cnt != '0);
    assign hold_o = st_q.hold;

endmodule

// File: rtl/rdw_wdt.sv
module rdw_wdt #(
    parameter int PERIOD = 576
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic hold_i,
    input  logic clr_i,
    output logic expire_o,
    output logic idle_o
);

    localparam int        CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wdt_t;

    wdt_t st_d, st_q;
    logic stop;

    always_comb begin
        stop     = !en_i || hold_i || clr_i;
        st_d     = st_q;
        expire_o = 1'b0;
        if (stop) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            expire_o = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o = (st_q.cnt == '0);

endmodule

// File: rtl/rdw_core_reset.sv
module rdw_core_reset
    import rdw_pkg::*;
#(
    parameter int DRT_CYCLES = 576,
    parameter int WDT_CYCLES = 576
) (
    input  logic clk_lf_i,
    input  logic por_i,
    input  logic mclr_n_i,
    input  logic sleep_i,
    input  logic wdt_clr_i,
    input  logic cfg_wdt_en_i,
    input  logic cfg_mclr_en_i,
    output logic core_rst_o,
    output logic wake_o,
    output logic to_flag_o,
    output logic gpin_o
);

    logic [SYN_W-1:0] syn_in, syn_out;
    logic pin_s, clr_s, sleep_s;
    logic mclr_hold, clr_rise, restart;
    logic drt_busy, wdt_expire, wdt_idle;
    top_state_t st_d, st_q;

    always_comb begin
        syn_in            = '0;
        syn_in[SYN_PIN]   = mclr_n_i;
        syn_in[SYN_CLR]   = wdt_clr_i;
        syn_in[SYN_SLEEP] = sleep_i;
    end

    rdw_sync #(
        .WIDTH   (SYN_W),
        .RST_VAL (SYN_IDLE)
    ) u_sync (
        .clk_i (clk_lf_i),
        .rst_i (por_i),
        .d_i   (syn_in),
        .q_o   (syn_out)
    );

    assign pin_s   = syn_out[SYN_PIN];
    assign clr_s   = syn_out[SYN_CLR];
    assign sleep_s = syn_out[SYN_SLEEP];

    assign mclr_hold = cfg_mclr_en_i && !pin_s;
    assign clr_rise  = clr_s && !st_q.clr_prev;
    assign restart   = mclr_hold || wdt_expire;

    rdw_drt #(
        .CYCLES (DRT_CYCLES)
    ) u_drt (
        .clk_i     (clk_lf_i),
        .rst_i     (por_i),
        .restart_i (restart),
        .busy_o    (drt_busy),
        .hold_o    (core_rst_o)
    );

    rdw_wdt #(
        .PERIOD (WDT_CYCLES)
    ) u_wdt (
        .clk_i    (clk_lf_i),
        .rst_i    (por_i),
        .en_i     (cfg_wdt_en_i),
        .hold_i   (drt_busy || mclr_hold),
        .clr_i    (clr_rise),
        .expire_o (wdt_expire),
        .idle_o   (wdt_idle)
    );

    always_comb begin
        st_d          = st_q;
        st_d.clr_prev = clr_s;
        st_d.wake     = wdt_expire && sleep_s;
        if (wdt_expire) begin
            st_d.to_flag = 1'b0;
        end else if (clr_rise) begin
            st_d.to_flag = 1'b1;
        end
    end

    always_ff @(posedge clk_lf_i or posedge por_i) begin
        if (por_i) begin
            st_q <= '{clr_prev: 1'b0, to_flag: 1'b1, wake: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o    = st_q.wake;
    assign to_flag_o = st_q.to_flag;
    assign gpin_o    = cfg_mclr_en_i ? 1'b0 : pin_s;

endmodule

// File: rtl/rdw_core_reset_chk.sv
module rdw_core_reset_chk (
    input logic clk_i,
    input logic por_i,
    input logic cfg_wdt_en_i,
    input logic core_rst_o,
    input logic wake_o,
    input logic to_flag_o,
    input logic wdt_expire,
    input logic wdt_idle,
    input logic mclr_hold,
    input logic clr_rise
);

    AST_MCLR_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (por_i)
        mclr_hold |=> core_rst_o); // R3

    AST_EXPIRE_RESETS: assert property (@(posedge clk_i) disable iff (por_i)
        wdt_expire |=> core_rst_o); // R4

    AST_WDT_IDLE_IN_RESET: assert property (@(posedge clk_i) disable iff (por_i)
        core_rst_o |-> wdt_idle); // R4

    AST_WAKE_NEEDS_EXPIRE: assert property (@(posedge clk_i) disable iff (por_i)
        wake_o |-> $past(wdt_expire)); // R5

    AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (por_i)
        wake_o |=> !wake_o); // R5

    AST_EXPIRE_CLEARS_FLAG: assert property (@(posedge clk_i) disable iff (por_i)
        wdt_expire |=> !to_flag_o); // R6

    AST_WDT_OFF_IDLE: assert property (@(posedge clk_i) disable iff (por_i)
        !cfg_wdt_en_i |=> wdt_idle); // R7

    AST_CLEAR_SETS_FLAG: assert property (@(posedge clk_i) disable iff (por_i)
        clr_rise |=> to_flag_o); // R9

endmodule

bind rdw_core_reset rdw_core_reset_chk u_chk (
    .clk_i        (clk_lf_i),
    .por_i        (por_i),
    .cfg_wdt_en_i (cfg_wdt_en_i),
    .core_rst_o   (core_rst_o),
    .wake_o       (wake_o),
    .to_flag_o    (to_flag_o),
    .wdt_expire   (wdt_expire),
    .wdt_idle     (wdt_idle),
    .mclr_hold    (mclr_hold),
    .clr_rise     (clr_rise)
);

// File: tb/rdw_core_reset_bench.sv
module rdw_core_reset_bench;

    localparam int N = 16;
    localparam int W = 60;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic mclr_n = 1'b1;
    logic sleep = 1'b0;
    logic wclr = 1'b0;
    logic wdt_en = 1'b1;
    logic mclr_en = 1'b1;
    logic core_rst, wake, to_flag, gpin;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    rdw_core_reset #(
        .DRT_CYCLES (N),
        .WDT_CYCLES (W)
    ) u_rdw_core_reset (
        .clk_lf_i      (clk),
        .por_i         (por),
        .mclr_n_i      (mclr_n),
        .sleep_i       (sleep),
        .wdt_clr_i     (wclr),
        .cfg_wdt_en_i  (wdt_en),
        .cfg_mclr_en_i (mclr_en),
        .core_rst_o    (core_rst),
        .wake_o        (wake),
        .to_flag_o     (to_flag),
        .gpin_o        (gpin)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // Counts the hold that starts at the most recent restart edge
    task automatic hold_check(input string req);
        tick(N - 1);
        chk(req, "core_rst before release", core_rst, 1'b1);
        tick(1);
        chk(req, "core_rst after release", core_rst, 1'b0);
    endtask

    task automatic do_por();
        @(negedge clk);
        por = 1'b1;
        #1;
        chk("R1", "core_rst in por", core_rst, 1'b1);
        chk("R2", "to_flag in por", to_flag, 1'b1);
        chk("R2", "wake in por", wake, 1'b0);
        @(negedge clk);
        por = 1'b0;
        hold_check("R1");
    endtask

    task automatic test_expiry();
        do_por();
        tick(W - 1);
        chk("R4", "core_rst before expiry", core_rst, 1'b0);
        chk("R6", "to_flag before expiry", to_flag, 1'b1);
        tick(1);
        chk("R4", "core_rst at expiry", core_rst, 1'b1);
        chk("R6", "to_flag at expiry", to_flag, 1'b0);
        chk("R5", "wake outside sleep", wake, 1'b0);
        hold_check("R4");
    endtask

    task automatic test_sleep_wake();
        do_por();
        sleep = 1'b1;
        tick(W - 1);
        chk("R5", "wake before expiry", wake, 1'b0);
        chk("R4", "core_rst counting in sleep", core_rst, 1'b0);
        tick(1);
        chk("R5", "wake on expiry in sleep", wake, 1'b1);
        chk("R4", "core_rst on expiry in sleep", core_rst, 1'b1);
        tick(1);
        chk("R5", "wake one cycle only", wake, 1'b0);
        sleep = 1'b0;
    endtask

    task automatic test_clear();
        do_por();
        tick(W);
        chk("R6", "to_flag after expiry", to_flag, 1'b0);
        hold_check("R4");
        tick(W - 5);
        wclr = 1'b1;
        tick(2);
        chk("R9", "to_flag before clear lands", to_flag, 1'b0);
        tick(1);
        chk("R9", "to_flag after clear", to_flag, 1'b1);
        wclr = 1'b0;
        tick(2);
        chk("R8", "no expiry at old deadline", core_rst, 1'b0);
        tick(W - 3);
        chk("R8", "core_rst before new deadline", core_rst, 1'b0);
        tick(1);
        chk("R8", "core_rst at new deadline", core_rst, 1'b1);
    endtask

    task automatic test_mclr();
        do_por();
        mclr_n = 1'b0;
        tick(2);
        chk("R3", "core_rst two edges after pin low", core_rst, 1'b0);
        tick(1);
        chk("R3", "core_rst three edges after pin low", core_rst, 1'b1);
        tick(10);
        chk("R3", "core_rst while pin low", core_rst, 1'b1);
        mclr_n = 1'b1;
        tick(N + 1);
        chk("R3", "core_rst before release", core_rst, 1'b1);
        tick(1);
        chk("R3", "core_rst after release", core_rst, 1'b0);
    endtask

    task automatic test_mclr_off();
        do_por();
        mclr_en = 1'b0;
        #1;
        chk("R10", "gpin with pin high", gpin, 1'b1);
        @(negedge clk);
        mclr_n = 1'b0;
        tick(1);
        chk("R10", "gpin one edge after pin low", gpin, 1'b1);
        tick(1);
        chk("R10", "gpin two edges after pin low", gpin, 1'b0);
        tick(10);
        chk("R10", "core_rst with pin ignored", core_rst, 1'b0);
        mclr_n = 1'b1;
        tick(2);
        chk("R10", "gpin back high", gpin, 1'b1);
        mclr_en = 1'b1;
        #1;
        chk("R10", "gpin when pin is reset source", gpin, 1'b0);
        tick(3);
        chk("R10", "core_rst after re-enable", core_rst, 1'b0);
    endtask

    task automatic test_wdt_off();
        wdt_en = 1'b0;
        do_por();
        tick(2 * W);
        chk("R7", "core_rst with watchdog off", core_rst, 1'b0);
        chk("R7", "to_flag with watchdog off", to_flag, 1'b1);
        tick(W);
        chk("R7", "core_rst long after", core_rst, 1'b0);
        wdt_en = 1'b1;
    endtask

    initial begin
        test_expiry();
        test_sleep_wake();
        test_clear();
        test_mclr();
        test_mclr_off();
        test_wdt_off();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): got running expected finished");
        summary();
        $finish;
    end

endmodule